// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a first-in first-out buffer between two free-running clocks. The write side takes an 18-bit word on a `wr_clk` rising edge. The read side presents words on `rd_data`. A holding register sits in front of the read port and is loaded automatically. As soon as the storage array holds a word and the holding register is empty, the oldest word falls through to the output and `out_rdy` rises, with no read request. A read pops the word in the holding register and loads the next one behind it. The storage array has 1024 entries and the holding register adds one more, so the buffer holds 1025 words when full.

Each domain sees the other side's pointer only through a Gray-coded two-flop synchroniser. This gives fixed, multi-cycle flag latencies. A single active-low reset is shared by both domains. Each domain registers the reset twice before acting on it, so reset must be held across several edges of both clocks. Widths, depth and synchroniser length are parameters. The defaults are 18 bits, 1024 entries and two stages.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a `wr_clk` rising edge only when `in_rdy`, `wr_en_a` and `wr_en_b` are all high. With any of them low, nothing is stored.
- R2: The word in the holding register is replaced by the next stored word on a `rd_clk` rising edge only when `out_rdy`, `out_en`, `rd_en_a` and `rd_en_b` are all high. Otherwise it stays unchanged and `out_rdy` stays high.
- R3: The first word written into an empty buffer appears on `rd_data` on the third `rd_clk` rising edge after the write edge, and `out_rdy` rises on that same edge. `rd_en_a` and `rd_en_b` may be low throughout.
- R4: `out_rdy` falls on the `rd_clk` edge that reads the last stored word.
- R5: With no reads, exactly 1025 words (array depth plus one) are accepted. `in_rdy` is low right after the filling write, and a write attempted while it is low is dropped.
- R6: Once full, `in_rdy` is low after the first `wr_clk` edge that follows a read, and high after the second.
- R7: While `rst_n` is low, `in_rdy` goes low on the second `wr_clk` edge and `out_rdy` on the third `rd_clk` edge. After at least four edges of each clock, `half_full` is low and all stored words are discarded.
- R8: After `rst_n` rises, `in_rdy` stays low across the first `wr_clk` edge and is high after the second.
- R9: When `out_en` is high, `rd_data` equals the held word bit for bit, not inverted. When `out_en` is low, `rd_data` is all zero.
- R10: `half_full` is high when the write domain counts at least 512 words in the array behind the holding register, which is 513 or more words in all. With 512 words in all it is low.
- R11: Words leave in the order they were accepted, whatever the ratio of the two clocks and the pattern of the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset shared by both domains |
| wr_data | input | 18 | Word to store |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| in_rdy | output | 1 | Buffer can accept a word |
| half_full | output | 1 | At least 513 words held, as seen from the write domain |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable; zeroes `rd_data` when low |
| rd_data | output | 18 | Held word |
| out_rdy | output | 1 | A valid word is held at the output |

## Verification
A corrupted read or write pointer shows at `rd_data` on the very next pop, either as a repeated, skipped or stale word. The queue-model comparison catches it on every read. A fault in a synchroniser or in the full or empty compare moves a flag by one or more edges. The bench counts the exact edge on which `out_rdy` and `in_rdy` change after a write, a read, an assertion of reset and its release. A full-compare error shows as a capacity other than 1025 words, and an error in the occupancy arithmetic moves `half_full` off the 512/513 boundary.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

   localparam int DEF_DATA_W = 18;
   localparam int DEF_ADDR_W = 10;
   localparam int DEF_SYNC   = 2;

   // Reflected-binary to binary, evaluated over a fixed 32-bit container.
   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xclk_sync.sv
module xclk_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (clr) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xclk_ram.sv
module xclk_ram #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 10
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/xclk_wr_ctl.sv
module xclk_wr_ctl
   import xclk_fifo_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = ADDR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_a,
   input  logic             en_b,
   input  logic [PTR_W-1:0] rgray_async,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] wgray,
   output logic             push,
   output logic             in_rdy,
   output logic             half_full
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [1:0]       rst_sh;
   logic             live;
   logic [PTR_W-1:0] rgray_s;
   logic [PTR_W-1:0] rbin;
   logic [PTR_W-1:0] occ;
   logic [PTR_W-1:0] wnext;
   logic             full;

   always_ff @(posedge clk) rst_sh <= {rst_sh[0], rst_n};
   assign live = rst_sh[1];

   xclk_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(clk), .clr(!live), .d(rgray_async), .q(rgray_s)
   );

   assign full   = (wgray == {~rgray_s[PTR_W-1:PTR_W-2], rgray_s[PTR_W-3:0]});
   assign in_rdy = live & ~full;
   assign push   = in_rdy & en_a & en_b;
   assign wnext  = wptr + 1'b1;

   always_ff @(posedge clk) begin
      if (!live) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (push) begin
         wptr  <= wnext;
         wgray <= wnext ^ (wnext >> 1);
      end
   end

   assign rbin      = PTR_W'(gray_to_bin(32'(rgray_s)));
   assign occ       = wptr - rbin;
   assign half_full = live & (occ >= PTR_W'(DEPTH / 2));

endmodule

// File: rtl/xclk_rd_ctl.sv
module xclk_rd_ctl #(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_a,
   input  logic              en_b,
   input  logic              oe,
   input  logic [PTR_W-1:0]  wgray_async,
   input  logic [DATA_W-1:0] mem_word,
   output logic [PTR_W-1:0]  rptr,
   output logic [PTR_W-1:0]  rgray,
   output logic [DATA_W-1:0] q_word,
   output logic              out_rdy
);

   logic [1:0]       rst_sh;
   logic             live;
   logic [PTR_W-1:0] wgray_s;
   logic [PTR_W-1:0] rnext;
   logic             mem_empty;
   logic             take;
   logic             refill;

   always_ff @(posedge clk) rst_sh <= {rst_sh[0], rst_n};
   assign live = rst_sh[1];

   xclk_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(clk), .clr(!live), .d(wgray_async), .q(wgray_s)
   );

   assign mem_empty = (rgray == wgray_s);
   assign take      = out_rdy & oe & en_a & en_b;
   assign refill    = ~out_rdy | take;
   assign rnext     = rptr + 1'b1;

   always_ff @(posedge clk) begin
      if (!live) begin
         rptr    <= '0;
         rgray   <= '0;
         q_word  <= '0;
         out_rdy <= 1'b0;
      end else if (refill) begin
         if (!mem_empty) begin
            q_word  <= mem_word;
            rptr    <= rnext;
            rgray   <= rnext ^ (rnext >> 1);
            out_rdy <= 1'b1;
         end else begin
            out_rdy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
   parameter int DATA_W        = xclk_fifo_pkg::DEF_DATA_W,
   parameter int ADDR_W        = xclk_fifo_pkg::DEF_ADDR_W,
   parameter int SYNC_STAGES   = xclk_fifo_pkg::DEF_SYNC,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en_a,
   input  logic              wr_en_b,
   output logic              in_rdy,
   output logic              half_full,
   input  logic              rd_en_a,
   input  logic              rd_en_b,
   input  logic              out_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_rdy
);

   localparam int PTR_W = ADDR_W + 1;

   if (DATA_W < 1) begin : g_bad_data
      $error("xclk_fifo: DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr
      $error("xclk_fifo: ADDR_W must lie in 2..20");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xclk_fifo: SYNC_STAGES must be at least 2");
   end

   logic [PTR_W-1:0]  wr_ptr, wr_gray, rd_ptr, rd_gray;
   logic [DATA_W-1:0] q_word, mem_word;
   logic              push;

   xclk_wr_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
      .rgray_async(rd_gray), .wptr(wr_ptr), .wgray(wr_gray),
      .push(push), .in_rdy(in_rdy), .half_full(half_full)
   );

   xclk_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wclk(wr_clk), .we(push), .waddr(wr_ptr[ADDR_W-1:0]), .wdata(wr_data),
      .raddr(rd_ptr[ADDR_W-1:0]), .rdata(mem_word)
   );

   xclk_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b), .oe(out_en),
      .wgray_async(wr_gray), .mem_word(mem_word), .rptr(rd_ptr), .rgray(rd_gray),
      .q_word(q_word), .out_rdy(out_rdy)
   );

   if (ZERO_WHEN_OFF) begin : g_zero_off
      assign rd_data = out_en ? q_word : '0;
   end else begin : g_pass
      assign rd_data = q_word;
   end

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
   parameter int DATA_W = 18,
   parameter int PTR_W  = 11
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              wr_en_a,
   input logic              wr_en_b,
   input logic              in_rdy,
   input logic              rd_en_a,
   input logic              rd_en_b,
   input logic              out_en,
   input logic              out_rdy,
   input logic [PTR_W-1:0]  wr_ptr,
   input logic [PTR_W-1:0]  rd_ptr,
   input logic [DATA_W-1:0] q_word
);

   AST_IDLE_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (in_rdy && !(wr_en_a && wr_en_b)) |=> $stable(wr_ptr)); // R1

   AST_HOLD_WORD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (out_rdy && !(out_en && rd_en_a && rd_en_b)) |=> (out_rdy && $stable(q_word))); // R2

   AST_FIRST_WORD_POPS: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(out_rdy) |-> (rd_ptr != $past(rd_ptr))); // R3

   AST_OR_FALLS_ON_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(out_rdy) |-> $past(out_en && rd_en_a && rd_en_b)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !in_rdy |=> $stable(wr_ptr)); // R5

endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
   .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .in_rdy(in_rdy),
   .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en), .out_rdy(out_rdy),
   .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .q_word(q_word)
);

// File: tb/tb_xclk_fifo.sv
`timescale 1ns/1ps
module tb_xclk_fifo;

   localparam int DW    = 18;
   localparam int DEPTH = 1024;

   // {enable a, enable b, data}
   localparam logic [19:0] WTAB [16] = '{
      20'hC0011, 20'h80022, 20'h40033, 20'h00044,
      20'hFFFFF, 20'hC0000, 20'hD5555, 20'hAAAAA,
      20'h6AAAA, 20'hC1234, 20'hC1234, 20'h81111,
      20'hF0F0F, 20'h4FFFF, 20'hC0001, 20'hE8001
   };

   logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_en_a = 1'b0, wr_en_b = 1'b0, rd_en_a = 1'b0, rd_en_b = 1'b0, out_en = 1'b1;
   logic in_rdy, half_full, out_rdy;
   logic [DW-1:0] rd_data;

   int checks = 0, errors = 0;
   logic [DW-1:0] model [$];

   xclk_fifo dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
      .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .in_rdy(in_rdy), .half_full(half_full),
      .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en), .rd_data(rd_data),
      .out_rdy(out_rdy)
   );

   always #10 wr_clk = ~wr_clk;
   initial begin
      #3.7;
      forever #13.3 rd_clk = ~rd_clk;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wcyc(input logic a, input logic b, input logic [DW-1:0] d, output logic acc);
      @(negedge wr_clk);
      wr_en_a = a; wr_en_b = b; wr_data = d;
      acc = in_rdy & a & b;
      @(posedge wr_clk);
      if (acc) model.push_back(d);
      #0.01;
      wr_en_a = 1'b0; wr_en_b = 1'b0;
   endtask

   task automatic rcyc(input logic a, input logic b, input logic e, input string tag, output logic took);
      logic [DW-1:0] exp;
      @(negedge rd_clk);
      rd_en_a = a; rd_en_b = b; out_en = e;
      took = out_rdy & a & b & e;
      if (took) begin
         if (model.size() == 0) chk({tag, " unexpected word"}, 32'(rd_data), 32'hDEAD);
         else begin
            exp = model.pop_front();
            chk(tag, 32'(rd_data), 32'(exp));
         end
      end
      @(posedge rd_clk);
      #0.01;
      rd_en_a = 1'b0; rd_en_b = 1'b0; out_en = 1'b1;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic acc, took;
      int n;

      // Reset state and release timing
      repeat (6) @(posedge rd_clk);
      #1;
      chk("R7 in_rdy in reset", 32'(in_rdy), 0);
      chk("R7 out_rdy in reset", 32'(out_rdy), 0);
      chk("R7 half_full in reset", 32'(half_full), 0);
      chk("R7 rd_data in reset", 32'(rd_data), 0);
      @(negedge wr_clk) rst_n = 1'b1;
      @(posedge wr_clk); #1 chk("R8 in_rdy first edge", 32'(in_rdy), 0);
      @(posedge wr_clk); #1 chk("R8 in_rdy second edge", 32'(in_rdy), 1);
      repeat (4) @(posedge rd_clk);

      // Fall-through with read enables low
      wcyc(1'b1, 1'b1, 18'h2A5A5, acc);
      repeat (2) @(posedge rd_clk);
      #1 chk("R3 out_rdy before third edge", 32'(out_rdy), 0);
      @(posedge rd_clk);
      #1 chk("R3 out_rdy on third edge", 32'(out_rdy), 1);
      chk("R3 first word", 32'(rd_data), 32'h2A5A5);
      wcyc(1'b1, 1'b1, 18'h1B3C4, acc);
      repeat (4) @(posedge rd_clk);

      // Partial read enables hold the word
      rcyc(1'b1, 1'b0, 1'b1, "R2", took);
      #1 chk("R2 hold a-only", 32'(rd_data), 32'h2A5A5);
      rcyc(1'b0, 1'b1, 1'b1, "R2", took);
      #1 chk("R2 hold b-only", 32'(rd_data), 32'h2A5A5);
      rcyc(1'b1, 1'b1, 1'b0, "R2", took);
      #1 chk("R2 hold oe-low", 32'(rd_data), 32'h2A5A5);
      chk("R2 out_rdy held", 32'(out_rdy), 1);

      // Output enable gating
      @(negedge rd_clk) out_en = 1'b0;
      #1 chk("R9 zero when disabled", 32'(rd_data), 0);
      out_en = 1'b1;
      #1 chk("R9 word when enabled", 32'(rd_data), 32'h2A5A5);

      rcyc(1'b1, 1'b1, 1'b1, "R2 pop", took);
      #1 chk("R2 next word", 32'(rd_data), 32'h1B3C4);
      rcyc(1'b1, 1'b1, 1'b1, "R4 pop", took);
      #1 chk("R4 out_rdy after last", 32'(out_rdy), 0);

      // Table of write-enable patterns, then drain in order
      for (int i = 0; i < 16; i++) wcyc(WTAB[i][19], WTAB[i][18], WTAB[i][17:0], acc);
      while (model.size() > 0) rcyc(1'b1, 1'b1, 1'b1, "R1 R11 table word", took);
      repeat (4) @(posedge rd_clk);
      #1 chk("R1 nothing extra stored", 32'(out_rdy), 0);

      // Unrelated clocks, patterned enables on both sides
      fork
         begin
            int nw = 0;
            for (int i = 0; nw < 300; i++) begin
               logic a;
               wcyc((i % 4) != 3, 1'b1, 18'(i * 7 + 3), a);
               if (a) nw++;
            end
         end
         begin
            int nr = 0;
            for (int j = 0; nr < 300; j++) begin
               logic t;
               rcyc((j % 5) != 2, 1'b1, 1'b1, "R11 stream", t);
               if (t) nr++;
            end
         end
      join
      repeat (4) @(posedge rd_clk);
      #1 chk("R11 empty after stream", 32'(out_rdy), 0);

      // Fill with no reads: half-full boundary and capacity
      n = 0;
      for (int i = 0; i < 512; i++) begin
         wcyc(1'b1, 1'b1, 18'(i ^ 18'h15A5A), acc);
         if (acc) n++;
      end
      repeat (6) @(posedge wr_clk);
      #1 chk("R10 half_full at 512", 32'(half_full), 0);
      wcyc(1'b1, 1'b1, 18'h3C3C3, acc);
      if (acc) n++;
      repeat (3) @(posedge wr_clk);
      #1 chk("R10 half_full at 513", 32'(half_full), 1);
      acc = 1'b1;
      for (int i = 0; acc && i < 2 * DEPTH; i++) begin
         wcyc(1'b1, 1'b1, 18'(i + 18'h20000), acc);
         if (acc) n++;
      end
      chk("R5 capacity", 32'(n), DEPTH + 1);
      chk("R5 in_rdy low when full", 32'(in_rdy), 0);

      // Recovery after one read
      rcyc(1'b1, 1'b1, 1'b1, "R6 pop", took);
      @(posedge wr_clk); #1 chk("R6 in_rdy first edge", 32'(in_rdy), 0);
      @(posedge wr_clk); #1 chk("R6 in_rdy second edge", 32'(in_rdy), 1);

      // Reset while holding data
      @(negedge wr_clk) rst_n = 1'b0;
      fork
         begin
            @(posedge wr_clk); #1 chk("R7 in_rdy first reset edge", 32'(in_rdy), 1);
            @(posedge wr_clk); #1 chk("R7 in_rdy second reset edge", 32'(in_rdy), 0);
         end
         begin
            repeat (2) @(posedge rd_clk);
            #1 chk("R7 out_rdy second reset edge", 32'(out_rdy), 1);
            @(posedge rd_clk); #1 chk("R7 out_rdy third reset edge", 32'(out_rdy), 0);
         end
      join
      repeat (6) @(posedge rd_clk);
      #1 chk("R7 half_full after reset", 32'(half_full), 0);
      model.delete();
      @(negedge wr_clk) rst_n = 1'b1;
      repeat (8) @(posedge rd_clk);
      #1 chk("R7 contents discarded", 32'(out_rdy), 0);
      chk("R7 in_rdy after release", 32'(in_rdy), 1);

      // Normal operation resumes
      wcyc(1'b1, 1'b1, 18'h0BEEF, acc);
      repeat (4) @(posedge rd_clk);
      rcyc(1'b1, 1'b1, 1'b1, "R11 after reset", took);
      chk("R3 fall-through after reset", 32'(took), 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule